// File: doc/BRIEF.md
# Two-Bank SDRAM Command Sequencer

This block sits between a simple host port and a 16-bit synchronous DRAM organised as two banks of 2048 rows by 256 columns. It brings the memory out of power-up, programs its mode register, and then turns each host request into one access. An access is an activate, then a single-word read or write, then a precharge of that bank. Between accesses it inserts an auto-refresh whenever the refresh interval has run out. Every minimum spacing between commands is derived from nanosecond parameters and a clock-period parameter. Each one is rounded up to whole clocks.

The host offers a request with `req_valid` and holds it, with all of its fields stable, until a cycle in which `req_ready` is also high. That cycle is the hand-off. `req_ready` is low while an access or refresh is in flight, while a refresh is owed, and throughout initialisation. This is the only back-pressure. Read data returns on `rd_valid`/`rd_data` as a one-cycle pulse with no ready: the host must always take it. Read data returns in request order, because accesses never overlap.

The memory data bus is split into `sd_dq_out`, `sd_dq_oe` and `sd_dq_in`, so that the pad ring can build the bidirectional pin. The single bank pin `sd_ba` drives the memory's top address bit.

Top module: `sdr_ctrl`

## Requirements
- R1: After reset only NOP is issued for at least INIT_C clocks (default 10000, i.e. 100 µs at 10 ns). Then the commands PRECHARGE with `sd_addr[10]`=1 (all banks), AUTO REFRESH, AUTO REFRESH and MODE REGISTER SET follow, with `sd_addr` = CL<<4 (burst length 1, sequential, default 11'h020). `req_ready` stays low until at least 2 clocks after the mode-register command.
- R2: Commands are encoded on {cs_n,ras_n,cas_n,we_n} as MRS=0000, REFRESH=0001, PRECHARGE=0010, ACTIVATE=0011, WRITE=0100, READ=0101 and NOP=0111. No other code is ever driven.
- R3: The 20-bit host word address maps as bank = bit 19, row = bits 18:8 (sent with ACTIVATE) and column = bits 7:0 (sent with READ/WRITE). `sd_addr[10]` is 0 on READ, WRITE and on the per-access PRECHARGE, which goes to the same bank.
- R4: READ or WRITE follows its ACTIVATE by at least tRCD (2 clocks by default).
- R5: PRECHARGE follows ACTIVATE by at least tRAS (4 clocks) and follows a WRITE by at least 2 clocks.
- R6: ACTIVATE and REFRESH follow a PRECHARGE by at least tRP (2 clocks). A command after a REFRESH waits at least tRC (5 clocks).
- R7: Once initialisation is done, consecutive auto-refreshes are at most REFI_C+16 clocks apart (REFI_C default 1560). An owed refresh is served before a waiting host request.
- R8: On the WRITE cycle `sd_dq_oe`=1, `sd_dq_out` carries the request data and `sd_dqm` = ~`req_be`. Bit 0 is the low byte, and a set `sd_dqm` bit masks that byte. `sd_dq_oe` is 0 on every other cycle.
- R9: `rd_valid` pulses exactly CL+1 cycles after the cycle in which READ is on the pins. It carries the word that the memory drove CL cycles after that READ.
- R10: A request is taken only in a cycle with `req_valid` and `req_ready` both high. Each request taken yields exactly one ACTIVATE. `req_ready` is never high in a cycle that drives a command other than NOP.
- R11: `sd_cke` is low during reset and high from the first clock after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request offered |
| req_ready | output | 1 | Controller can take the request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address {bank,row,column} |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = low byte |
| rd_valid | output | 1 | Read data pulse |
| rd_data | output | 16 | Read data |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 1 | Bank select (memory top address bit) |
| sd_addr | output | 11 | Row / column / flag address |
| sd_dqm | output | 2 | Byte masks |
| sd_dq_out | output | 16 | Write data to pads |
| sd_dq_oe | output | 1 | Pad output enable |
| sd_dq_in | input | 16 | Read data from pads |

## Verification
All command pins are registered. A command decided in one cycle therefore appears on the pins one clock later, and the bench measures every spacing between pin-level commands in whole cycles sampled on the falling edge. The bench's memory model drives read data in the cycle CL after it sees READ. It then expects `rd_valid` exactly CL+1 cycles after READ and compares `rd_data` with a host-side shadow that merges bytes by enable. Refresh gaps are measured between consecutive post-initialisation refreshes, and the mode word is checked at its single appearance.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    ST_WAIT, ST_IPRE, ST_IREF1, ST_IREF2, ST_IMRS, ST_IDLE, ST_RW, ST_PRE
  } sdr_state_e;

  function automatic int unsigned ns_to_clk(int unsigned t_ns, int unsigned clk_ns);
    return (t_ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdr_refresh_tick.sv
module sdr_refresh_tick #(
  parameter int unsigned REFI_C = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic served,
  output logic owed
);
  localparam int unsigned CW = $clog2(REFI_C + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      owed <= 1'b0;
    end else begin
      if (served) owed <= 1'b0;
      if (cnt == CW'(REFI_C - 1)) begin
        cnt  <= '0;
        owed <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdr_rd_capture.sv
module sdr_rd_capture #(
  parameter int unsigned CL = 2,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [DW-1:0] dq_in,
  output logic          valid,
  output logic [DW-1:0] data
);
  logic [CL:0] pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pipe  <= '0;
      valid <= 1'b0;
      data  <= '0;
    end else begin
      pipe  <= {pipe[CL-1:0], issue};
      valid <= pipe[CL];
      if (pipe[CL]) data <= dq_in;
    end
  end
endmodule

// File: rtl/sdr_ctrl.sv
module sdr_ctrl
  import sdr_pkg::*;
#(
  parameter int unsigned CLK_NS    = 10,
  parameter int unsigned T_INIT_NS = 100000,
  parameter int unsigned T_REFI_NS = 15600,
  parameter int unsigned T_RCD_NS  = 15,
  parameter int unsigned T_RP_NS   = 15,
  parameter int unsigned T_RAS_NS  = 35,
  parameter int unsigned T_RC_NS   = 50,
  parameter int unsigned T_DPL_CLK = 2,
  parameter int unsigned T_MRD_CLK = 2,
  parameter int unsigned CL        = 2,
  parameter int unsigned ROW_W     = 11,
  parameter int unsigned COL_W     = 8,
  parameter int unsigned DW        = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_we,
  input  logic [ROW_W+COL_W:0]       req_addr,
  input  logic [DW-1:0]              req_wdata,
  input  logic [DW/8-1:0]            req_be,
  output logic                       rd_valid,
  output logic [DW-1:0]              rd_data,
  output logic                       sd_cke,
  output logic                       sd_cs_n,
  output logic                       sd_ras_n,
  output logic                       sd_cas_n,
  output logic                       sd_we_n,
  output logic                       sd_ba,
  output logic [ROW_W-1:0]           sd_addr,
  output logic [DW/8-1:0]            sd_dqm,
  output logic [DW-1:0]              sd_dq_out,
  output logic                       sd_dq_oe,
  input  logic [DW-1:0]              sd_dq_in
);
  localparam int unsigned AW       = ROW_W + COL_W + 1;
  localparam int unsigned INIT_C   = ns_to_clk(T_INIT_NS, CLK_NS);
  localparam int unsigned REFI_C   = ns_to_clk(T_REFI_NS, CLK_NS);
  localparam int unsigned RCD_C    = ns_to_clk(T_RCD_NS, CLK_NS);
  localparam int unsigned RP_C     = ns_to_clk(T_RP_NS, CLK_NS);
  localparam int unsigned RAS_C    = ns_to_clk(T_RAS_NS, CLK_NS);
  localparam int unsigned RC_C     = ns_to_clk(T_RC_NS, CLK_NS);
  localparam int unsigned RAS_REST = max_u(RAS_C, RCD_C + 1) - RCD_C;
  localparam int unsigned WR_PRE_C = max_u(T_DPL_CLK, RAS_REST);
  localparam int unsigned RD_PRE_C = max_u(1, RAS_REST);
  localparam int unsigned PRE_GAP  = max_u(RP_C, max_u(RC_C, RAS_C + RP_C) - RAS_C);
  localparam int unsigned CNT_W    = $clog2(INIT_C + 2);
  localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CL << 4);

  sdr_state_e         state, ret_q, ret_n;
  logic [CNT_W-1:0]   cnt;
  sdr_cmd_e           cmd_q, cmd_n;
  logic [ROW_W-1:0]   addr_n;
  logic               ba_n, wr_n, go, take, ref_owed, ref_go;
  int unsigned        gap;
  logic               op_we, op_bank;
  logic [COL_W-1:0]   op_col;
  logic [DW-1:0]      op_wdata;
  logic [DW/8-1:0]    op_be;

  assign req_ready = (state == ST_IDLE) && !ref_owed;
  assign take      = req_ready && req_valid;
  assign ref_go    = (state == ST_IDLE) && ref_owed;
  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

  always_comb begin
    cmd_n  = CMD_NOP;
    addr_n = '0;
    ba_n   = 1'b0;
    wr_n   = 1'b0;
    go     = 1'b0;
    gap    = 0;
    ret_n  = ST_IDLE;
    unique case (state)
      ST_IPRE:  begin cmd_n = CMD_PRE; addr_n[10] = 1'b1; go = 1'b1; gap = RP_C; ret_n = ST_IREF1; end
      ST_IREF1: begin cmd_n = CMD_REF; go = 1'b1; gap = RC_C; ret_n = ST_IREF2; end
      ST_IREF2: begin cmd_n = CMD_REF; go = 1'b1; gap = RC_C; ret_n = ST_IMRS; end
      ST_IMRS:  begin cmd_n = CMD_MRS; addr_n = MODE_WORD; go = 1'b1; gap = T_MRD_CLK; ret_n = ST_IDLE; end
      ST_IDLE: begin
        if (ref_go) begin
          cmd_n = CMD_REF; go = 1'b1; gap = RC_C; ret_n = ST_IDLE;
        end else if (take) begin
          cmd_n  = CMD_ACT;
          ba_n   = req_addr[AW-1];
          addr_n = req_addr[AW-2:COL_W];
          go = 1'b1; gap = RCD_C; ret_n = ST_RW;
        end
      end
      ST_RW: begin
        cmd_n  = op_we ? CMD_WR : CMD_RD;
        ba_n   = op_bank;
        addr_n = ROW_W'(op_col);
        wr_n   = op_we;
        go = 1'b1; gap = op_we ? WR_PRE_C : RD_PRE_C; ret_n = ST_PRE;
      end
      ST_PRE: begin cmd_n = CMD_PRE; ba_n = op_bank; go = 1'b1; gap = PRE_GAP; ret_n = ST_IDLE; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_WAIT;
      ret_q     <= ST_IPRE;
      cnt       <= CNT_W'(INIT_C + 1);
      cmd_q     <= CMD_NOP;
      sd_cke    <= 1'b0;
      sd_ba     <= 1'b0;
      sd_addr   <= '0;
      sd_dqm    <= '1;
      sd_dq_out <= '0;
      sd_dq_oe  <= 1'b0;
      op_we     <= 1'b0;
      op_bank   <= 1'b0;
      op_col    <= '0;
      op_wdata  <= '0;
      op_be     <= '0;
    end else begin
      sd_cke    <= 1'b1;
      cmd_q     <= cmd_n;
      sd_ba     <= ba_n;
      sd_addr   <= addr_n;
      sd_dq_oe  <= wr_n;
      sd_dq_out <= op_wdata;
      sd_dqm    <= wr_n ? ~op_be : '0;
      if (take && !ref_go) begin
        op_we    <= req_we;
        op_bank  <= req_addr[AW-1];
        op_col   <= req_addr[COL_W-1:0];
        op_wdata <= req_wdata;
        op_be    <= req_be;
      end
      if (go) begin
        if (gap <= 1) begin
          state <= ret_n;
        end else begin
          state <= ST_WAIT;
          ret_q <= ret_n;
          cnt   <= CNT_W'(gap - 1);
        end
      end else if (state == ST_WAIT) begin
        if (cnt <= 1) state <= ret_q;
        else          cnt   <= cnt - 1'b1;
      end
    end
  end

  sdr_refresh_tick #(.REFI_C(REFI_C)) refresh_i (
    .clk(clk), .rst_n(rst_n), .served(ref_go), .owed(ref_owed)
  );

  sdr_rd_capture #(.CL(CL), .DW(DW)) capture_i (
    .clk(clk), .rst_n(rst_n),
    .issue((state == ST_RW) && !op_we),
    .dq_in(sd_dq_in), .valid(rd_valid), .data(rd_data)
  );

endmodule

// File: rtl/sdr_ctrl_chk.sv
module sdr_ctrl_chk
  import sdr_pkg::*;
#(
  parameter int unsigned RCD_C = 2,
  parameter int unsigned RAS_C = 4,
  parameter int unsigned RP_C  = 2,
  parameter int unsigned DPL_C = 2,
  parameter int unsigned CL    = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] cmd,
  input logic       a10,
  input logic       cke,
  input logic       dq_oe,
  input logic       rd_valid,
  input logic       req_ready
);
  logic [15:0] since_act, since_pre, since_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act <= '1;
      since_pre <= '1;
      since_wr  <= '1;
    end else begin
      since_act <= (cmd == CMD_ACT) ? 16'd1 : ((since_act == '1) ? since_act : since_act + 1'b1);
      since_pre <= (cmd == CMD_PRE) ? 16'd1 : ((since_pre == '1) ? since_pre : since_pre + 1'b1);
      since_wr  <= (cmd == CMD_WR)  ? 16'd1 : ((since_wr  == '1) ? since_wr  : since_wr  + 1'b1);
    end
  end

  assert_rcd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_RD || cmd == CMD_WR) |-> since_act >= 16'(RCD_C));
  assert_ras_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PRE && !a10) |-> since_act >= 16'(RAS_C));
  assert_dpl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PRE) |-> since_wr >= 16'(DPL_C));
  assert_rp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ACT || cmd == CMD_REF) |-> since_pre >= 16'(RP_C));
  assert_oe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe == (cmd == CMD_WR));
  assert_rd_lat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(cmd == CMD_RD, CL + 1));
  assert_ready_nop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> cmd == CMD_NOP);
  assert_cke_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cke);

endmodule

bind sdr_ctrl sdr_ctrl_chk #(
  .RCD_C(RCD_C), .RAS_C(RAS_C), .RP_C(RP_C), .DPL_C(T_DPL_CLK), .CL(CL)
) chk_i (
  .clk(clk), .rst_n(rst_n),
  .cmd({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}),
  .a10(sd_addr[10]), .cke(sd_cke), .dq_oe(sd_dq_oe),
  .rd_valid(rd_valid), .req_ready(req_ready)
);

// File: tb/sdr_ctrl_tb.sv
module sdr_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CL = 2;
  localparam int INIT_C = 10000;
  localparam int REFI_C = 1560;

  typedef struct {
    bit          we;
    logic [19:0] a;
    logic [15:0] d;
    logic [1:0]  be;
  } op_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic req_ready, rd_valid, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_dq_oe;
  logic [15:0] rd_data, sd_dq_out;
  logic [15:0] sd_dq_in = '0;
  logic [10:0] sd_addr;
  logic [1:0]  sd_dqm;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdr_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rd_valid(rd_valid), .rd_data(rd_data), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
    .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
    .sd_dq_in(sd_dq_in)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] merge(logic [15:0] o, logic [15:0] n, logic [1:0] be);
    return {be[1] ? n[15:8] : o[15:8], be[0] ? n[7:0] : o[7:0]};
  endfunction

  // host-side shadow and scoreboards
  logic [15:0] shadow [int unsigned];
  op_t         opq[$];
  logic [15:0] rd_exp[$];
  int          rd_cyc[$];
  int          accepted = 0;

  // memory model state
  logic [15:0] mem [int unsigned];
  int  cyc = 0, last_act = -100, last_pre = -100, last_ref = -100, last_wr = -100;
  int  init_step = 0, mrs_cyc = -1, acts = 0, idle_refs = 0, last_idle_ref = -1;
  bit  ready_seen = 0, cur_we = 0;
  op_t cur;
  logic        pv [0:3];
  logic [15:0] pd [0:3];
  initial for (int i = 0; i < 4; i++) begin pv[i] = 1'b0; pd[i] = '0; end

  always @(negedge clk) begin
    logic [3:0] c;
    logic [15:0] rv;
    bit is_rd;
    is_rd = 0; rv = '0;
    if (rst_n) begin
      cyc++;
      c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      if (!(c inside {4'b0000, 4'b0001, 4'b0010, 4'b0011, 4'b0100, 4'b0101, 4'b0111}))
        check(0, "R2 illegal command code", c, 4'b0111);
      if (req_ready && !ready_seen) begin
        ready_seen = 1;
        check(mrs_cyc > 0 && cyc - mrs_cyc >= 2, "R1 ready after MRS", cyc - mrs_cyc, 2);
      end
      if (init_step < 4 && c != 4'b0111) begin
        case (init_step)
          0: begin
            check(c == 4'b0010 && sd_addr[10], "R1 first cmd precharge-all", {c, sd_addr[10]}, 5'b00101);
            check(cyc >= INIT_C, "R1 init wait", cyc, INIT_C);
          end
          1, 2: check(c == 4'b0001, "R1 init refresh", c, 4'b0001);
          3: begin
            check(c == 4'b0000 && sd_addr == 11'h020, "R1 mode word", {c, sd_addr}, 15'h0020);
            mrs_cyc = cyc;
          end
          default: ;
        endcase
        if (c == 4'b0010) last_pre = cyc;
        if (c == 4'b0001) begin
          check(cyc - last_pre >= 2 && cyc - last_ref >= 5, "R6 init refresh spacing", cyc - last_ref, 5);
          last_ref = cyc;
        end
        init_step++;
      end else if (c != 4'b0111) begin
        case (c)
          4'b0011: begin
            acts++;
            check(cyc - last_pre >= 2, "R6 PRE->ACT", cyc - last_pre, 2);
            check(cyc - last_ref >= 5, "R6 REF->ACT", cyc - last_ref, 5);
            if (opq.size() == 0) check(0, "R10 ACT without request", 1, 0);
            else begin
              cur = opq.pop_front();
              check({sd_ba, sd_addr} == cur.a[19:8], "R3 bank/row", {sd_ba, sd_addr}, cur.a[19:8]);
            end
            last_act = cyc;
          end
          4'b0100, 4'b0101: begin
            check(cyc - last_act >= 2, "R4 ACT->RW", cyc - last_act, 2);
            check(sd_addr == {3'b000, cur.a[7:0]} && sd_ba == cur.a[19] && (c == 4'b0100) == cur.we,
                  "R3 column/op", {sd_ba, sd_addr}, {cur.a[19], 3'b000, cur.a[7:0]});
            cur_we = (c == 4'b0100);
            if (cur_we) begin
              check(sd_dq_oe && sd_dq_out == cur.d && sd_dqm == ~cur.be, "R8 write data/mask",
                    {sd_dq_oe, sd_dqm, sd_dq_out}, {1'b1, ~cur.be, cur.d});
              mem[cur.a] = merge(mem.exists(cur.a) ? mem[cur.a] : 16'h0, sd_dq_out, ~sd_dqm);
              last_wr = cyc;
            end else begin
              is_rd = 1;
              rv = mem.exists(cur.a) ? mem[cur.a] : 16'h0;
              rd_cyc.push_back(cyc);
            end
          end
          4'b0010: begin
            check(!sd_addr[10] && sd_ba == cur.a[19], "R3 precharge bank", {sd_addr[10], sd_ba}, {1'b0, cur.a[19]});
            check(cyc - last_act >= 4, "R5 ACT->PRE", cyc - last_act, 4);
            if (cur_we) check(cyc - last_wr >= 2, "R5 WR->PRE", cyc - last_wr, 2);
            last_pre = cyc;
          end
          4'b0001: begin
            check(cyc - last_pre >= 2 && cyc - last_ref >= 5, "R6 refresh spacing", cyc - last_ref, 5);
            if (last_idle_ref >= 0)
              check(cyc - last_idle_ref <= REFI_C + 16, "R7 refresh interval", cyc - last_idle_ref, REFI_C + 16);
            last_idle_ref = cyc;
            idle_refs++;
            last_ref = cyc;
          end
          default: check(0, "R2 unexpected command", c, 4'b0111);
        endcase
      end
      if (c != 4'b0100 && sd_dq_oe) check(0, "R8 oe outside write", 1, 0);
      if (rd_valid) begin
        if (rd_exp.size() == 0) check(0, "R9 unexpected rd_valid", 1, 0);
        else begin
          int rc;
          logic [15:0] ev;
          rc = rd_cyc.pop_front();
          ev = rd_exp.pop_front();
          check(cyc - rc == CL + 1, "R9 read latency", cyc - rc, CL + 1);
          check(rd_data == ev, "R9 read data", rd_data, ev);
        end
      end
    end
    for (int i = 3; i > 0; i--) begin pv[i] = pv[i-1]; pd[i] = pd[i-1]; end
    pv[0] = is_rd; pd[0] = rv;
    sd_dq_in = pv[CL] ? pd[CL] : 16'h0BAD;
  end

  task automatic host_op(input bit we, input logic [19:0] a, input logic [15:0] d, input logic [1:0] be);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    begin
      op_t o;
      o.we = we; o.a = a; o.d = d; o.be = be;
      opq.push_back(o);
    end
    accepted++;
    if (we) shadow[a] = merge(shadow.exists(a) ? shadow[a] : 16'h0, d, be);
    else    rd_exp.push_back(shadow.exists(a) ? shadow[a] : 16'h0);
    @(negedge clk);
    req_valid = 1'b0;
    req_wdata = $urandom;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL R10 watchdog expired actual=hung expected=complete");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (4) @(negedge clk);
    check(sd_cke == 1'b0, "R11 cke low in reset", sd_cke, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(sd_cke == 1'b1, "R11 cke high after reset", sd_cke, 1);
    check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111 && !req_ready, "R1 NOP and not ready",
          {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, req_ready}, 5'b01110);
    // directed corners: address extremes, byte-lane merges, unwritten read
    host_op(1, 20'h00000, 16'hA5A5, 2'b11);
    host_op(0, 20'h00000, 16'h0, 2'b11);
    host_op(1, 20'hFFFFF, 16'h1234, 2'b11);
    host_op(1, 20'hFFFFF, 16'hCDEE, 2'b01);
    host_op(0, 20'hFFFFF, 16'h0, 2'b11);
    host_op(1, 20'hFFFFF, 16'h77AA, 2'b10);
    host_op(0, 20'hFFFFF, 16'h0, 2'b11);
    host_op(0, 20'h80000, 16'h0, 2'b11);
    host_op(1, 20'h7FF00, 16'hBEEF, 2'b00);
    host_op(0, 20'h7FF00, 16'h0, 2'b11);
    // constrained random traffic spanning several refresh intervals
    for (int n = 0; n < 900; n++) begin
      logic [19:0] a;
      logic [10:0] row;
      logic [7:0]  col;
      row = ($urandom % 2) ? 11'h7FF : 11'($urandom % 4);
      col = 8'($urandom % 8) | ((($urandom % 4) == 0) ? 8'hF8 : 8'h00);
      a = {1'($urandom % 2), row, col};
      host_op(($urandom % 2) == 1, a, 16'($urandom), 2'($urandom % 4));
      repeat ($urandom % 4) @(negedge clk);
    end
    repeat (50) @(negedge clk);
    check(acts == accepted, "R10 one ACT per accepted request", acts, accepted);
    check(rd_exp.size() == 0, "R9 all reads returned", rd_exp.size(), 0);
    check(idle_refs >= 3, "R7 refreshes issued", idle_refs, 3);
    finish_run();
  end
endmodule